// File: doc/BRIEF.md
# Event-Driven Pin Action Unit

This unit sits inside a 32-pin port and lets four event inputs change the port's output register without any processor write. A 32-bit control word sets up each of the four channels. For each channel it gives the target pin, the action and an enable. While a channel is enabled, its event input can force the target pin's output bit to the event level, set it, clear it or invert it.

Each channel turns its event and its settings into per-pin set, clear and toggle requests. The unit merges the requests of all four channels. It then combines them with any bus write to the output register in the same cycle, and the result is registered as the new pin output word. The control word is loaded as a whole through a single write port. An event that arrives in the same cycle as a control write is still handled with the old settings.

Top module: `evpin_unit`

## Requirements
- R1: On synchronous reset the control word and the output word are both zero, so every channel is disabled and events have no effect on `pin_out`.
- R2: Channel n is set by control bits 8n+7 down to 8n. Within that byte, bits 4:0 hold the target pin number, bits 6:5 hold the action code and bit 7 is the enable.
- R3: A channel whose enable bit is 0 leaves the output word unchanged, whatever its action code and event input.
- R4: Action code 1 (set) drives the target bit of `pin_out` to 1 on the clock edge that samples an event pulse.
- R5: Action code 2 (clear) drives the target bit of `pin_out` to 0 on the clock edge that samples an event pulse.
- R6: Action code 3 (toggle) inverts the target bit on the edge that samples the pulse. A single-cycle pulse inverts the bit exactly once.
- R7: Action code 0 (drive) copies the channel's event level into the target bit on every clock edge while the channel is enabled.
- R8: A bus write to the output word in the same cycle as event actions is applied first, and the event actions modify the written value.
- R9: Several toggles on one bit in the same cycle combine by parity. An even count leaves the bit unchanged.
- R10: On one bit in one cycle, a set or a clear overrides any toggle. A clear overrides a set.
- R11: A control write takes effect from the next cycle. An event in the same cycle as the write uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads the whole control word |
| cfg_wdata | input | 32 | New control word |
| ev_in | input | 4 | Event inputs, one per channel |
| out_we | input | 1 | Bus write strobe for the output word |
| out_wdata | input | 32 | Bus write data for the output word |
| pin_out | output | 32 | Registered pin output word |

## Verification
The bench first tries each action alone on separate pins: set, clear, toggle and drive. A drive pulse held for several cycles shows the difference between following the level and acting once per pulse. Same-cycle stimulus then shows how the pieces combine. Two or three toggles on one pin separate parity from a plain OR. Mixed set, clear and toggle requests on shared pins expose the priority order. A bus write together with an event shows whether the write or the event action is applied first. A control write together with an event shows when new settings take hold, and a disabled but fully configured channel shows that the enable gates its action.

// File: rtl/evpin_pkg.sv
package evpin_pkg;

    localparam int NPINS   = 32;
    localparam int NCH     = 4;
    localparam int PIN_W   = $clog2(NPINS);
    localparam int ACT_W   = 2;
    localparam int FIELD_W = PIN_W + ACT_W + 1;
    localparam int CFG_W   = NCH * FIELD_W;

    typedef enum logic [ACT_W-1:0] {
        ACT_DRIVE = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_FLIP  = 2'd3
    } act_e;

    // packed MSB first: enable, action, pin number
    typedef struct packed {
        logic             en;
        act_e             act;
        logic [PIN_W-1:0] pin;
    } chan_cfg_t;

    typedef struct packed {
        logic [NPINS-1:0] set;
        logic [NPINS-1:0] clr;
        logic [NPINS-1:0] tgl;
    } pin_req_t;

    function automatic chan_cfg_t field_of(input logic [CFG_W-1:0] w, input int n);
        return chan_cfg_t'(w[n*FIELD_W +: FIELD_W]);
    endfunction

    function automatic logic [NPINS-1:0] pin_onehot(input logic [PIN_W-1:0] p);
        logic [NPINS-1:0] v;
        v    = '0;
        v[p] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/evpin_cfg_reg.sv
module evpin_cfg_reg
    import evpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output chan_cfg_t        cfg [NCH]
);
    logic [CFG_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)     word_q <= '0;
        else if (we) word_q <= wdata;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_split
        assign cfg[n] = field_of(word_q, n);
    end

    AST_CFG_RESET: assert property (@(posedge clk) rst |=> (word_q == '0)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(word_q)); // R11

endmodule

// File: rtl/evpin_chan.sv
module evpin_chan
    import evpin_pkg::*;
(
    input  chan_cfg_t cfg,
    input  logic      ev,
    output pin_req_t  req
);
    logic [NPINS-1:0] hit;

    always_comb begin
        hit = pin_onehot(cfg.pin);
        req = '0;
        if (cfg.en) begin
            unique case (cfg.act)
                ACT_DRIVE: begin
                    if (ev) req.set = hit;
                    else    req.clr = hit;
                end
                ACT_SET:   if (ev) req.set = hit;
                ACT_CLEAR: if (ev) req.clr = hit;
                ACT_FLIP:  if (ev) req.tgl = hit;
                default:   req = '0;
            endcase
        end
    end

endmodule

// File: rtl/evpin_out_reg.sv
module evpin_out_reg
    import evpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [NPINS-1:0] bus_wdata,
    input  pin_req_t         req,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] base;
    logic [NPINS-1:0] nxt;
    logic [NPINS-1:0] flip_only;

    always_comb begin
        base = bus_we ? bus_wdata : q;
        nxt  = ((base ^ req.tgl) | req.set) & ~req.clr;
        flip_only = bus_we ? '0 : (req.tgl & ~req.set & ~req.clr);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_OUT_RESET: assert property (@(posedge clk) rst |=> (q == '0)); // R1
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(req.set & ~req.clr)) == $past(req.set & ~req.clr))); // R4
    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(req.clr)) == '0)); // R5
    AST_FLIP_LANDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((q ^ $past(q)) & $past(flip_only)) == $past(flip_only))); // R6

endmodule

// File: rtl/evpin_unit.sv
module evpin_unit
    import evpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NCH-1:0]   ev_in,
    input  logic             out_we,
    input  logic [NPINS-1:0] out_wdata,
    output logic [NPINS-1:0] pin_out
);
    chan_cfg_t cfg [NCH];
    pin_req_t  reqs [NCH];
    pin_req_t  merged;
    logic      any_en;

    evpin_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        evpin_chan u_chan (
            .cfg (cfg[n]),
            .ev  (ev_in[n]),
            .req (reqs[n])
        );
    end

    always_comb begin
        merged = '0;
        any_en = 1'b0;
        for (int n = 0; n < NCH; n++) begin
            merged.set = merged.set | reqs[n].set;
            merged.clr = merged.clr | reqs[n].clr;
            merged.tgl = merged.tgl ^ reqs[n].tgl;
            any_en     = any_en | cfg[n].en;
        end
    end

    evpin_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (out_we),
        .bus_wdata (out_wdata),
        .req       (merged),
        .q         (pin_out)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!any_en && !out_we) |=> $stable(pin_out)); // R3
    AST_BUS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (out_we && !any_en) |=> (pin_out == $past(out_wdata))); // R8

endmodule

// File: tb/sim_evpin_unit.sv
module sim_evpin_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  ev_in = '0;
    logic        out_we = 1'b0;
    logic [31:0] out_wdata = '0;
    logic [31:0] pin_out;

    int total = 0;
    int fails = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] m_out = '0;
    logic [31:0] m_cfg = '0;

    always #2.5 clk = ~clk;

    evpin_unit u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ev_in(ev_in), .out_we(out_we), .out_wdata(out_wdata), .pin_out(pin_out)
    );

    // byte layout per channel: [7] enable, [6:5] action, [4:0] pin
    function automatic logic [7:0] fld(input logic en, input logic [1:0] act, input logic [4:0] pin);
        return {en, act, pin};
    endfunction

    function automatic logic [31:0] predict(input logic [31:0] q, input logic [3:0] ev,
                                            input logic we, input logic [31:0] wd,
                                            input logic [31:0] c);
        logic [31:0] s, k, t, b;
        s = '0; k = '0; t = '0;
        b = we ? wd : q;
        for (int n = 0; n < 4; n++) begin
            logic [7:0] f;
            f = c[8*n +: 8];
            if (f[7]) begin
                case (f[6:5])
                    2'd0: if (ev[n]) s[f[4:0]] = 1'b1; else k[f[4:0]] = 1'b1;
                    2'd1: if (ev[n]) s[f[4:0]] = 1'b1;
                    2'd2: if (ev[n]) k[f[4:0]] = 1'b1;
                    default: if (ev[n]) t[f[4:0]] = ~t[f[4:0]];
                endcase
            end
        end
        return ((b ^ t) | s) & ~k;
    endfunction

    task automatic step(input logic [3:0] ev, input logic we, input logic [31:0] wd,
                        input logic cwe, input logic [31:0] cwd, input string tag);
        @(negedge clk);
        ev_in = ev; out_we = we; out_wdata = wd; cfg_we = cwe; cfg_wdata = cwd;
        m_out = predict(m_out, ev, we, wd, m_cfg);
        if (cwe) m_cfg = cwd;
        exp_q.push_back(m_out);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(4'b0000, 1'b0, '0, 1'b0, '0, tag);
    endtask

    // monitor: compare each registered result against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (pin_out !== e) begin
                    fails++;
                    $display("FAIL %s: pin_out=%h expected=%h", t, pin_out, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        total++;
        if (pin_out !== 32'h0) begin
            fails++;
            $display("FAIL R1: pin_out=%h expected=%h", pin_out, 32'h0);
        end
        // R1: control word is zero, events do nothing
        step(4'b1111, 1'b0, '0, 1'b0, '0, "R1");
        // R11: write config with ch0 set pin5; the simultaneous event uses old config
        step(4'b0001, 1'b0, '0, 1'b1,
             {fld(1, 2'd0, 5'd0), fld(1, 2'd3, 5'd31), fld(1, 2'd2, 5'd5), fld(1, 2'd1, 5'd5)}, "R11");
        step(4'b0001, 1'b0, '0, 1'b0, '0, "R4");
        idle("R4");
        step(4'b0010, 1'b0, '0, 1'b0, '0, "R5");
        // R2: channel 2 in bits 23:16 targets pin 31
        step(4'b0100, 1'b0, '0, 1'b0, '0, "R2");
        idle("R6");
        step(4'b0100, 1'b0, '0, 1'b0, '0, "R6");
        idle("R6");
        // R7: drive follows level for several cycles
        step(4'b1000, 1'b0, '0, 1'b0, '0, "R7");
        step(4'b1000, 1'b0, '0, 1'b0, '0, "R7");
        step(4'b1000, 1'b0, '0, 1'b0, '0, "R7");
        step(4'b0000, 1'b0, '0, 1'b0, '0, "R7");
        // R8: bus write then toggle pin31 and drive pin0 on top
        step(4'b1100, 1'b1, 32'h1234_5678, 1'b0, '0, "R8");
        step(4'b0000, 1'b1, 32'hFFFF_0000, 1'b0, '0, "R8");
        // R9: three channels toggle pin7
        step(4'b0000, 1'b0, '0, 1'b1,
             {fld(0, 2'd3, 5'd7), fld(1, 2'd3, 5'd7), fld(1, 2'd3, 5'd7), fld(1, 2'd3, 5'd7)}, "R9");
        step(4'b0011, 1'b0, '0, 1'b0, '0, "R9");
        step(4'b0111, 1'b0, '0, 1'b0, '0, "R9");
        step(4'b0110, 1'b0, '0, 1'b0, '0, "R9");
        // R10: set beats toggle on pin9, clear beats toggle on pin10
        step(4'b0000, 1'b0, '0, 1'b1,
             {fld(1, 2'd3, 5'd10), fld(1, 2'd2, 5'd10), fld(1, 2'd3, 5'd9), fld(1, 2'd1, 5'd9)}, "R10");
        step(4'b1111, 1'b0, '0, 1'b0, '0, "R10");
        step(4'b0000, 1'b1, 32'h0000_0400, 1'b1,
             {fld(0, 2'd0, 5'd0), fld(0, 2'd0, 5'd0), fld(1, 2'd2, 5'd3), fld(1, 2'd1, 5'd3)}, "R10");
        step(4'b0011, 1'b0, '0, 1'b0, '0, "R10");
        // R3: all channels configured but disabled
        step(4'b0000, 1'b1, 32'hA5A5_A5A5, 1'b1,
             {fld(0, 2'd2, 5'd0), fld(0, 2'd3, 5'd2), fld(0, 2'd1, 5'd1), fld(0, 2'd0, 5'd5)}, "R3");
        step(4'b1111, 1'b0, '0, 1'b0, '0, "R3");
        step(4'b0000, 1'b0, '0, 1'b0, '0, "R3");
        repeat (3) @(posedge clk);
        #1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule